// File: doc/BRIEF.md
# Exception Context Stacking Sequencer

This block carries out the hardware side of taking an interrupt and of returning from one. A take strobe brings an interrupt number and a flag saying whether floating-point state is live. The block then copies a context frame from the register file onto a single downward-growing stack through a word-wide memory write port. Next it fetches the handler address from a vector table and finally rewrites the stack pointer, the link register, the interrupt-number status field and the program counter. The frame holds 8 words for integer-only context and 26 words when floating-point state is active. The size is recorded in the link value that the block writes.

On return, the core hands the block the target of a branch to the link register. If the target is one of the two special return values, the block reads the frame back from the stack, writes every saved word into its register, and moves the stack pointer back past the frame. Any other target is an ordinary branch, and the block ignores it.

Register-file indices used on the read and write ports are: 0 to 15 for the core registers (13 stack pointer, 14 link, 15 program counter), 16 for the whole program status word, and 32+j for floating-point context word j (j = 0..17). The read port is combinational: data for `rf_rd_idx_o` is expected in the same cycle.

Top module: `exc_ctx_seq`

## Requirements
- R1: For a take with floating-point state inactive, the block writes 8 words at new_sp+0 through new_sp+28, and new_sp is the stack pointer minus 32. In address order the words are registers 0, 1, 2, 3, 12, 14, 15 and 16, so register 0 sits at new_sp. Every write address is word aligned.
- R2: With floating-point state active, the block writes 26 words and new_sp is the stack pointer minus 104. The 8 integer words are laid out as in R1. Floating-point word j (register index 32+j) goes to new_sp+32+4j.
- R3: After a take completes, register 13 holds new_sp.
- R4: After a take completes, register 14 holds 0xFFFFFFF9 for an 8-word frame and 0xFFFFFFE9 for a 26-word frame.
- R5: During a take, `irq_num_we_o` pulses once with `irq_num_o` equal to the taken number. Register 15 ends up holding the word read from `vtor_i` + 4 × number.
- R6: A return strobe whose target has bits [31:5] all ones and bits [3:0] equal to 9 starts unstacking. Bit 4 set means 8 words and bit 4 clear means 26 words. Each word read from stack_pointer+4k is written to the register it was saved from, and register 13 then becomes the old stack pointer plus 4 × words. No memory write happens on return.
- R7: A return strobe with any other target is an ordinary branch. It leaves busy low and issues no memory access and no register write.
- R8: `busy_o` is low after reset and rises in the cycle after an accepted strobe. `done_o` is a one-cycle pulse during busy that coincides with the final register write (program counter on a take, stack pointer on a return). Busy is low in the next cycle.
- R9: Memory requests use valid/ready. While valid is high and ready is low, address and data hold steady and valid stays high. Write and read requests are never raised together. Each read request gets exactly one response, marked by `mem_rrsp_valid_i`, which is always accepted.
- R10: Strobes that arrive while busy are ignored. When a take and a return arrive in the same idle cycle, the take wins and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Interrupt take strobe |
| take_irq_i | input | IRQ_W | Number of the interrupt being taken |
| take_fp_i | input | 1 | Floating-point state active at take |
| ret_i | input | 1 | Branch-to-link strobe |
| ret_target_i | input | 32 | Branch target value |
| sp_i | input | 32 | Current stack pointer |
| vtor_i | input | 32 | Vector table base address |
| rf_rd_idx_o | output | 6 | Register-file read index |
| rf_rd_data_i | input | 32 | Register-file read data (same cycle) |
| rf_wr_en_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 6 | Register-file write index |
| rf_wr_data_o | output | 32 | Register-file write data |
| irq_num_we_o | output | 1 | Status interrupt-number field write strobe |
| irq_num_o | output | IRQ_W | Value for the interrupt-number field |
| mem_wvalid_o | output | 1 | Memory write request valid |
| mem_wready_i | input | 1 | Memory write request ready |
| mem_waddr_o | output | 32 | Memory write byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_o | output | 1 | Memory read request valid |
| mem_rready_i | input | 1 | Memory read request ready |
| mem_raddr_o | output | 32 | Memory read byte address |
| mem_rrsp_valid_i | input | 1 | Memory read response valid |
| mem_rrsp_data_i | input | 32 | Memory read response data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions check the handshake rules on every cycle: requests hold steady under back-pressure, the two memory ports are never both requested, and writes are aligned. They also check that busy, done and strobe acceptance are ordered correctly, and that the block stays silent while idle or after an ordinary branch. Only the bench scenarios can show that the right data ends up in the right places. That covers the frame contents and word order for both frame sizes, the final stack pointer, the link value, the interrupt number, the vectored program counter, and the exact restore of a clobbered register file on return. The scenarios also show strobe priority and that strobes arriving while busy are ignored.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int XLEN       = 32;
  localparam int IDX_W      = 6;
  localparam int BASE_WORDS = 8;

  localparam logic [IDX_W-1:0] IDX_R12  = 6'd12;
  localparam logic [IDX_W-1:0] IDX_SP   = 6'd13;
  localparam logic [IDX_W-1:0] IDX_LR   = 6'd14;
  localparam logic [IDX_W-1:0] IDX_PC   = 6'd15;
  localparam logic [IDX_W-1:0] IDX_STAT = 6'd16;
  localparam logic [IDX_W-1:0] IDX_FP0  = 6'd32;

  localparam logic [XLEN-1:0] LINK_INT = 32'hFFFF_FFF9;
  localparam logic [XLEN-1:0] LINK_FP  = 32'hFFFF_FFE9;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH,
    S_VREQ,
    S_VWAIT,
    S_SET_SP,
    S_SET_LR,
    S_SET_PC,
    S_POP_REQ,
    S_POP_WAIT,
    S_POP_SP
  } seq_state_e;
endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
  import exc_seq_pkg::*;
(
  input  logic [XLEN-1:0] target_i,
  output logic            special_o,
  output logic            fp_frame_o
);
  // Special when every bit above the size flag is set and the low nibble
  // selects a return onto the main stack.
  assign special_o  = (&target_i[XLEN-1:5]) && (target_i[3:0] == 4'h9);
  assign fp_frame_o = ~target_i[4];
endmodule

// File: rtl/exc_slot_map.sv
module exc_slot_map
  import exc_seq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0]    slot_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    if (slot_i < CW'(4)) begin
      idx_o = IDX_W'(slot_i);
    end else begin
      case (slot_i)
        CW'(4):  idx_o = IDX_R12;
        CW'(5):  idx_o = IDX_LR;
        CW'(6):  idx_o = IDX_PC;
        CW'(7):  idx_o = IDX_STAT;
        default: idx_o = IDX_FP0 + IDX_W'(slot_i - CW'(BASE_WORDS));
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_walker.sv
module exc_frame_walker
  import exc_seq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [CW-1:0]   nwords_i,
  input  logic            step_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] base_o,
  output logic [XLEN-1:0] end_o,
  output logic [CW-1:0]   slot_o,
  output logic            last_o
);
  logic [XLEN-1:0] base_q;
  logic [CW-1:0]   slot_q;
  logic [CW-1:0]   n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      slot_q <= '0;
      n_q    <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      slot_q <= '0;
      n_q    <= nwords_i;
    end else if (step_i) begin
      slot_q <= slot_q + CW'(1);
    end
  end

  assign addr_o = base_q + XLEN'({slot_q, 2'b00});
  assign end_o  = base_q + XLEN'({n_q, 2'b00});
  assign base_o = base_q;
  assign slot_o = slot_q;
  assign last_o = (slot_q == n_q - CW'(1));
endmodule

// File: rtl/exc_ctx_seq.sv
module exc_ctx_seq
  import exc_seq_pkg::*;
#(
  parameter int IRQ_W    = 6,
  parameter int FP_WORDS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [IRQ_W-1:0]  take_irq_i,
  input  logic              take_fp_i,
  input  logic              ret_i,
  input  logic [XLEN-1:0]   ret_target_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [XLEN-1:0]   vtor_i,
  output logic [IDX_W-1:0]  rf_rd_idx_o,
  input  logic [XLEN-1:0]   rf_rd_data_i,
  output logic              rf_wr_en_o,
  output logic [IDX_W-1:0]  rf_wr_idx_o,
  output logic [XLEN-1:0]   rf_wr_data_o,
  output logic              irq_num_we_o,
  output logic [IRQ_W-1:0]  irq_num_o,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [XLEN-1:0]   mem_waddr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              mem_rvalid_o,
  input  logic              mem_rready_i,
  output logic [XLEN-1:0]   mem_raddr_o,
  input  logic              mem_rrsp_valid_i,
  input  logic [XLEN-1:0]   mem_rrsp_data_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAX_WORDS = BASE_WORDS + FP_WORDS;
  localparam int CW        = $clog2(MAX_WORDS + 1);
  localparam logic [CW-1:0] N_INT = CW'(BASE_WORDS);
  localparam logic [CW-1:0] N_FP  = CW'(MAX_WORDS);

  seq_state_e       st;
  logic [IRQ_W-1:0] irq_q;
  logic             fp_q;
  logic [XLEN-1:0]  vec_q;

  logic             ret_special, ret_fp;
  logic             walk_load, walk_step, walk_last;
  logic [XLEN-1:0]  walk_base_in, walk_addr, walk_base, walk_end;
  logic [CW-1:0]    walk_n, walk_slot;
  logic [IDX_W-1:0] slot_idx;
  logic             accept_take, accept_ret;

  exc_ret_decode u_dec (
    .target_i   (ret_target_i),
    .special_o  (ret_special),
    .fp_frame_o (ret_fp)
  );

  exc_slot_map #(.CW(CW)) u_map (
    .slot_i (walk_slot),
    .idx_o  (slot_idx)
  );

  exc_frame_walker #(.CW(CW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (walk_load),
    .base_i   (walk_base_in),
    .nwords_i (walk_n),
    .step_i   (walk_step),
    .addr_o   (walk_addr),
    .base_o   (walk_base),
    .end_o    (walk_end),
    .slot_o   (walk_slot),
    .last_o   (walk_last)
  );

  // Take has priority over return in the same idle cycle.
  assign accept_take = (st == S_IDLE) && take_i;
  assign accept_ret  = (st == S_IDLE) && !take_i && ret_i && ret_special;

  always_comb begin
    walk_load    = accept_take || accept_ret;
    walk_n       = accept_take ? (take_fp_i ? N_FP : N_INT)
                               : (ret_fp ? N_FP : N_INT);
    walk_base_in = accept_take ? (sp_i - XLEN'({walk_n, 2'b00})) : sp_i;
    walk_step    = ((st == S_PUSH) && mem_wready_i && !walk_last) ||
                   ((st == S_POP_WAIT) && mem_rrsp_valid_i && !walk_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      irq_q <= '0;
      fp_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (accept_take) begin
            st    <= S_PUSH;
            irq_q <= take_irq_i;
            fp_q  <= take_fp_i;
          end else if (accept_ret) begin
            st   <= S_POP_REQ;
            fp_q <= ret_fp;
          end
        end
        S_PUSH:     if (mem_wready_i && walk_last) st <= S_VREQ;
        S_VREQ:     if (mem_rready_i) st <= S_VWAIT;
        S_VWAIT: begin
          if (mem_rrsp_valid_i) begin
            vec_q <= mem_rrsp_data_i;
            st    <= S_SET_SP;
          end
        end
        S_SET_SP:   st <= S_SET_LR;
        S_SET_LR:   st <= S_SET_PC;
        S_SET_PC:   st <= S_IDLE;
        S_POP_REQ:  if (mem_rready_i) st <= S_POP_WAIT;
        S_POP_WAIT: if (mem_rrsp_valid_i) st <= walk_last ? S_POP_SP : S_POP_REQ;
        S_POP_SP:   st <= S_IDLE;
        default:    st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_rd_idx_o  = slot_idx;
    rf_wr_en_o   = 1'b0;
    rf_wr_idx_o  = '0;
    rf_wr_data_o = '0;
    irq_num_we_o = 1'b0;
    mem_wvalid_o = 1'b0;
    mem_waddr_o  = walk_addr;
    mem_wdata_o  = rf_rd_data_i;
    mem_rvalid_o = 1'b0;
    mem_raddr_o  = walk_addr;
    done_o       = 1'b0;
    unique case (st)
      S_PUSH: mem_wvalid_o = 1'b1;
      S_VREQ: begin
        mem_rvalid_o = 1'b1;
        mem_raddr_o  = vtor_i + XLEN'({irq_q, 2'b00});
      end
      S_SET_SP: begin
        rf_wr_en_o   = 1'b1;
        rf_wr_idx_o  = IDX_SP;
        rf_wr_data_o = walk_base;
        irq_num_we_o = 1'b1;
      end
      S_SET_LR: begin
        rf_wr_en_o   = 1'b1;
        rf_wr_idx_o  = IDX_LR;
        rf_wr_data_o = fp_q ? LINK_FP : LINK_INT;
      end
      S_SET_PC: begin
        rf_wr_en_o   = 1'b1;
        rf_wr_idx_o  = IDX_PC;
        rf_wr_data_o = vec_q;
        done_o       = 1'b1;
      end
      S_POP_REQ: mem_rvalid_o = 1'b1;
      S_POP_WAIT: begin
        rf_wr_en_o   = mem_rrsp_valid_i;
        rf_wr_idx_o  = slot_idx;
        rf_wr_data_o = mem_rrsp_data_i;
      end
      S_POP_SP: begin
        rf_wr_en_o   = 1'b1;
        rf_wr_idx_o  = IDX_SP;
        rf_wr_data_o = walk_end;
        done_o       = 1'b1;
      end
      default: ;
    endcase
  end

  assign irq_num_o = irq_q;
  assign busy_o    = (st != S_IDLE);
endmodule

// File: rtl/exc_ctx_seq_chk.sv
module exc_ctx_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_i,
  input logic        ret_i,
  input logic [31:0] ret_target_i,
  input logic        rf_wr_en_o,
  input logic        mem_wvalid_o,
  input logic        mem_wready_i,
  input logic [31:0] mem_waddr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_rvalid_o,
  input logic        mem_rready_i,
  input logic [31:0] mem_raddr_o,
  input logic        busy_o,
  input logic        done_o
);
  p_wr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid_o |-> (mem_waddr_o[1:0] == 2'b00));

  p_plain_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && !busy_o &&
     !((&ret_target_i[31:5]) && (ret_target_i[3:0] == 4'h9))) |=> !busy_o);

  p_take_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !busy_o) |=> busy_o);

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid_o && !mem_rready_i) |=> (mem_rvalid_o && $stable(mem_raddr_o)));

  p_one_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wvalid_o && mem_rvalid_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_wvalid_o && !mem_rvalid_o && !rf_wr_en_o));
endmodule

bind exc_ctx_seq exc_ctx_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .take_i       (take_i),
  .ret_i        (ret_i),
  .ret_target_i (ret_target_i),
  .rf_wr_en_o   (rf_wr_en_o),
  .mem_wvalid_o (mem_wvalid_o),
  .mem_wready_i (mem_wready_i),
  .mem_waddr_o  (mem_waddr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rvalid_o (mem_rvalid_o),
  .mem_rready_i (mem_rready_i),
  .mem_raddr_o  (mem_raddr_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/exc_ctx_seq_tb_top.sv
`timescale 1ns/1ps
module exc_ctx_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        take_i = 0, take_fp_i = 0, ret_i = 0;
  logic [5:0]  take_irq_i = '0;
  logic [31:0] ret_target_i = '0;
  logic [31:0] sp_i, vtor_i;
  logic [5:0]  rf_rd_idx_o, rf_wr_idx_o;
  logic [31:0] rf_rd_data_i, rf_wr_data_o;
  logic        rf_wr_en_o, irq_num_we_o;
  logic [5:0]  irq_num_o;
  logic        mem_wvalid_o, mem_wready_i, mem_rvalid_o, mem_rready_i;
  logic [31:0] mem_waddr_o, mem_wdata_o, mem_raddr_o;
  logic        mem_rrsp_valid_i;
  logic [31:0] mem_rrsp_data_i;
  logic        busy_o, done_o;

  exc_ctx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_irq_i(take_irq_i),
    .take_fp_i(take_fp_i), .ret_i(ret_i), .ret_target_i(ret_target_i),
    .sp_i(sp_i), .vtor_i(vtor_i), .rf_rd_idx_o(rf_rd_idx_o),
    .rf_rd_data_i(rf_rd_data_i), .rf_wr_en_o(rf_wr_en_o),
    .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
    .irq_num_we_o(irq_num_we_o), .irq_num_o(irq_num_o),
    .mem_wvalid_o(mem_wvalid_o), .mem_wready_i(mem_wready_i),
    .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_o(mem_rvalid_o), .mem_rready_i(mem_rready_i),
    .mem_raddr_o(mem_raddr_o), .mem_rrsp_valid_i(mem_rrsp_valid_i),
    .mem_rrsp_data_i(mem_rrsp_data_i), .busy_o(busy_o), .done_o(done_o)
  );

  // ---------------- bench models ----------------
  logic [31:0] rf  [0:63];
  logic [31:0] mem [0:1023];
  logic [31:0] snap[0:63];
  logic [5:0]  ipsr_q;
  logic        ld_go = 0, clob_go = 0, stall_en = 0;
  logic [7:0]  seed_v = 8'h00;
  logic [31:0] sp_seed = 32'h0;
  int          wr_cnt, rd_cnt;
  logic        req_seen;
  logic [31:0] req_addr;
  logic [7:0]  lf = 8'h5B;

  int n_chk = 0, n_err = 0;

  function automatic logic [31:0] rf_init(input logic [7:0] s, input int i);
    return {s, 8'(i), 16'h5A3C};
  endfunction

  function automatic logic [31:0] handler(input int j);
    return 32'h0000_8001 + 32'(j * 16);
  endfunction

  function automatic int slot_reg(input int k);
    case (k)
      0, 1, 2, 3: return k;
      4: return 12;
      5: return 14;
      6: return 15;
      7: return 16;
      default: return 32 + (k - 8);
    endcase
  endfunction

  assign rf_rd_data_i = rf[rf_rd_idx_o];
  assign sp_i         = rf[13];
  assign vtor_i       = 32'h0000_0100;

  always @(posedge clk) begin
    if (ld_go) begin
      for (int i = 0; i < 64; i++) rf[i] <= (i == 13) ? sp_seed : rf_init(seed_v, i);
      for (int j = 0; j < 64; j++) mem[64 + j] <= handler(j);
      wr_cnt <= 0;
      rd_cnt <= 0;
      ipsr_q <= '0;
    end else begin
      if (clob_go) begin
        for (int i = 0; i < 64; i++) if (i != 13) rf[i] <= ~rf[i];
      end else if (rf_wr_en_o) begin
        rf[rf_wr_idx_o] <= rf_wr_data_o;
      end
      if (irq_num_we_o) ipsr_q <= irq_num_o;
      if (mem_wvalid_o && mem_wready_i) begin
        mem[mem_waddr_o[11:2]] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rvalid_o && mem_rready_i) rd_cnt <= rd_cnt + 1;
    end
    req_seen <= mem_rvalid_o && mem_rready_i;
    req_addr <= mem_raddr_o;
  end

  always @(negedge clk) begin
    mem_rrsp_valid_i <= req_seen;
    mem_rrsp_data_i  <= mem[req_addr[11:2]];
    lf           <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_wready_i <= stall_en ? lf[0] : 1'b1;
    mem_rready_i <= stall_en ? lf[2] : 1'b1;
  end

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_o !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk({req, " watchdog"}, 32'd0, 32'd1);
    else chk({req, " busy with done"}, 32'(busy_o), 32'd1);
    @(negedge clk);
    chk({req, " busy low after done"}, 32'(busy_o), 32'd0);
  endtask

  task automatic load_state(input logic [7:0] s, input logic [31:0] sp, input bit stall);
    @(negedge clk);
    seed_v = s; sp_seed = sp; ld_go = 1;
    @(negedge clk);
    ld_go = 0; stall_en = stall;
    for (int i = 0; i < 64; i++) snap[i] = rf[i];
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R8 reset busy", 32'(busy_o), 0);
    chk("R8 reset done", 32'(done_o), 0);
    chk("R10 reset quiet", 32'({mem_wvalid_o, mem_rvalid_o, rf_wr_en_o}), 0);
  endtask

  task automatic t_entry(input bit fp, input logic [5:0] irq, input logic [31:0] sp,
                         input logic [7:0] s, input bit stall);
    int nw = fp ? 26 : 8;
    logic [31:0] nsp = sp - 32'(4 * nw);
    load_state(s, sp, stall);
    take_i = 1; take_irq_i = irq; take_fp_i = fp;
    @(negedge clk);
    take_i = 0;
    chk("R8 busy after take", 32'(busy_o), 1);
    wait_done("R8 entry");
    for (int k = 0; k < nw; k++)
      chk(k < 8 ? "R1 frame word" : "R2 fp frame word",
          mem[(nsp[11:2] + 10'(k))], snap[slot_reg(k)]);
    chk(fp ? "R2 word count" : "R1 word count", 32'(wr_cnt), 32'(nw));
    chk("R3 stack pointer", rf[13], nsp);
    chk("R4 link value", rf[14], fp ? 32'hFFFF_FFE9 : 32'hFFFF_FFF9);
    chk("R5 irq number", 32'(ipsr_q), 32'(irq));
    chk("R5 vectored pc", rf[15], handler(int'(irq)));
    stall_en = 0;
  endtask

  task automatic t_return(input bit fp);
    int nw = fp ? 26 : 8;
    logic [31:0] fsp;
    int wc;
    @(negedge clk);
    clob_go = 1;
    @(negedge clk);
    clob_go = 0;
    fsp = rf[13]; wc = wr_cnt;
    ret_i = 1; ret_target_i = fp ? 32'hFFFF_FFE9 : 32'hFFFF_FFF9;
    @(negedge clk);
    ret_i = 0;
    chk("R6 busy after return", 32'(busy_o), 1);
    wait_done("R6 return");
    for (int k = 0; k < nw; k++)
      chk("R6 restored register", rf[slot_reg(k)], snap[slot_reg(k)]);
    chk("R6 stack pointer restored", rf[13], fsp + 32'(4 * nw));
    chk("R6 no memory writes", 32'(wr_cnt), 32'(wc));
  endtask

  task automatic t_plain(input logic [31:0] tgt);
    logic [31:0] lr0 = rf[14], sp0 = rf[13];
    int rc = rd_cnt, wc = wr_cnt;
    ret_i = 1; ret_target_i = tgt;
    @(negedge clk);
    ret_i = 0;
    chk("R7 busy stays low", 32'(busy_o), 0);
    repeat (4) @(negedge clk);
    chk("R7 busy still low", 32'(busy_o), 0);
    chk("R7 no reads", 32'(rd_cnt), 32'(rc));
    chk("R7 no writes", 32'(wr_cnt), 32'(wc));
    chk("R7 sp unchanged", rf[13], sp0);
    chk("R7 lr unchanged", rf[14], lr0);
  endtask

  task automatic t_busy_ignore();
    load_state(8'h3C, 32'h0000_0C00, 1'b0);
    take_i = 1; take_irq_i = 6'd5; take_fp_i = 0;
    @(negedge clk);
    take_irq_i = 6'd9; take_fp_i = 1;
    ret_i = 1; ret_target_i = 32'hFFFF_FFF9;
    @(negedge clk);
    take_i = 0; ret_i = 0;
    wait_done("R10 busy ignore");
    chk("R10 second take ignored irq", 32'(ipsr_q), 5);
    chk("R10 second take ignored size", 32'(wr_cnt), 8);
    chk("R10 link from first take", rf[14], 32'hFFFF_FFF9);
    chk("R10 no stray reads", 32'(rd_cnt), 1);
  endtask

  task automatic t_take_wins();
    load_state(8'h77, 32'h0000_0D00, 1'b0);
    take_i = 1; take_irq_i = 6'd7; take_fp_i = 0;
    ret_i = 1; ret_target_i = 32'hFFFF_FFE9;
    @(negedge clk);
    take_i = 0; ret_i = 0;
    wait_done("R10 take wins");
    chk("R10 take wins irq", 32'(ipsr_q), 7);
    chk("R10 take wins writes", 32'(wr_cnt), 8);
    chk("R10 take wins sp", rf[13], 32'h0000_0D00 - 32'd32);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_entry(1'b0, 6'd3, 32'h0000_0C00, 8'h11, 1'b0);
    t_return(1'b0);
    t_entry(1'b1, 6'd42, 32'h0000_0C40, 8'h22, 1'b1);
    t_return(1'b1);
    t_entry(1'b0, 6'd63, 32'h0000_0BF0, 8'h33, 1'b1);
    t_return(1'b0);
    t_plain(32'h0000_2468);
    t_plain(32'hFFFF_FFD9);
    t_plain(32'hFFFF_FFF1);
    t_busy_ignore();
    t_take_wins();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule